// File: doc/BRIEF.md
# Select-Routed Adder Arithmetic Circuit

This block is a purely combinational arithmetic circuit of parametric width (32 bits by default). The adder always adds operand A to a second operand Y and a carry input. A two-bit select picks Y for every bit through a 4:1 multiplexer. Y can be B, the bitwise complement of B, all zeros or all ones. The adder is a ripple-carry chain of full adders, grouped into 4-bit ripple stages, and it gives a carry-out.

The datapath is the same for every operation. Only the routing into the adder and the carry input change. This gives seven functions:

| Function | Select | Carry in |
|---|---|---|
| Add | B | 0 |
| Add with carry | B | 1 |
| Subtract | complement of B | 1 |
| Subtract with borrow | complement of B | 0 |
| Transfer of A | zeros | 0 |
| Increment | zeros | 1 |
| Decrement | ones | 0 |

There is no clock and there are no registers. The outputs follow the inputs after the ripple delay.

Top module: `mux_adder_arith`

## Requirements
- R1: With y_sel=2'b00 (Y is B), {carry_out,sum_out} equals the 33-bit unsigned sum opa+opb+carry_in. This covers add and add with carry.
- R2: With y_sel=2'b01 (Y is the complement of B) and carry_in=1, sum_out equals opa-opb modulo 2^32. carry_out is 1 exactly when opa >= opb as unsigned values.
- R3: With y_sel=2'b01 and carry_in=0, sum_out equals opa-opb-1 modulo 2^32 (subtract with borrow). carry_out is 1 exactly when opa > opb as unsigned values.
- R4: With y_sel=2'b10 (Y is all zeros) and carry_in=0, sum_out equals opa and carry_out is 0, whatever opb holds.
- R5: With y_sel=2'b10 and carry_in=1, sum_out equals opa+1 modulo 2^32. carry_out is 1 only when opa is all ones.
- R6: With y_sel=2'b11 (Y is all ones) and carry_in=0, sum_out equals opa-1 modulo 2^32. carry_out is 1 unless opa is zero.
- R7: With y_sel=2'b11 and carry_in=1, sum_out equals opa and carry_out is 1, whatever opb holds.
- R8: The outputs depend only on the present inputs. A change of any input shows on the outputs within the same time step, with no clock and no dependence on earlier input values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 32 | First addend A |
| opb | input | 32 | Source operand B, routed by the select |
| y_sel | input | 2 | Selects Y: 00 B, 01 complement of B, 10 zeros, 11 ones |
| carry_in | input | 1 | Carry into bit 0 of the adder |
| sum_out | output | 32 | Low 32 bits of A+Y+carry_in |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
A wrong multiplexer leg for one bit corrupts sum_out at that bit, or at a higher bit through the carry, for any operand that exercises it. A broken carry link between two 4-bit stages shows only when a carry must cross that boundary. Operands such as all ones plus one, and 0x80000000, are therefore used. There is no state, so any fault shows in the same time step as the input that exposes it, and no earlier input can mask or delay it.

// File: rtl/mxa_pkg.sv
package mxa_pkg;
  typedef enum logic [1:0] {
    YS_B     = 2'b00,
    YS_NOTB  = 2'b01,
    YS_ZERO  = 2'b10,
    YS_ONES  = 2'b11
  } y_src_e;
endpackage

// File: rtl/mxa_operand_mux.sv
module mxa_operand_mux #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] b_val,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] y_val
);
  import mxa_pkg::*;
  y_src_e src;
  assign src = y_src_e'(sel);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (src)
        YS_B:    y_val[i] = b_val[i];
        YS_NOTB: y_val[i] = ~b_val[i];
        YS_ZERO: y_val[i] = 1'b0;
        default: y_val[i] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/mxa_full_adder.sv
module mxa_full_adder (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ ci;
  assign co = (x & y) | (ci & (x ^ y));
endmodule

// File: rtl/mxa_ripple_group.sv
module mxa_ripple_group #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] x,
  input  logic [GW-1:0] y,
  input  logic          ci,
  output logic [GW-1:0] s,
  output logic          co
);
  logic [GW:0] c;
  assign c[0] = ci;
  for (genvar k = 0; k < GW; k++) begin : g_fa
    mxa_full_adder u_fa (
      .x (x[k]),
      .y (y[k]),
      .ci(c[k]),
      .s (s[k]),
      .co(c[k+1])
    );
  end
  assign co = c[GW];
endmodule

// File: rtl/mux_adder_arith.sv
module mux_adder_arith #(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [1:0]       y_sel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  localparam int NGROUPS = WIDTH / GROUP;

  logic [WIDTH-1:0] y_val;
  logic [NGROUPS:0] gc;

  mxa_operand_mux #(.WIDTH(WIDTH)) u_mux (
    .b_val(opb),
    .sel  (y_sel),
    .y_val(y_val)
  );

  assign gc[0] = carry_in;
  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    mxa_ripple_group #(.GW(GROUP)) u_grp (
      .x (opa[g*GROUP +: GROUP]),
      .y (y_val[g*GROUP +: GROUP]),
      .ci(gc[g]),
      .s (sum_out[g*GROUP +: GROUP]),
      .co(gc[g+1])
    );
  end
  assign carry_out = gc[NGROUPS];
endmodule

// File: rtl/mxa_checker.sv
module mxa_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [1:0]       y_sel,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum_out,
  input logic             carry_out
);
  logic known;
  assign known = !$isunknown({opa, opb, y_sel, carry_in, sum_out, carry_out});

  always_comb begin
    if (known && y_sel == 2'b00) begin
      p_add_r1: assert ({carry_out, sum_out} ==
                        ({1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, carry_in}))
        else $error("R1 add mismatch");
    end
    if (known && y_sel == 2'b01 && carry_in) begin
      p_sub_r2: assert (sum_out == opa - opb && carry_out == (opa >= opb))
        else $error("R2 subtract mismatch");
    end
    if (known && y_sel == 2'b01 && !carry_in) begin
      p_sbb_r3: assert (sum_out == opa - opb - 1'b1 && carry_out == (opa > opb))
        else $error("R3 borrow mismatch");
    end
    if (known && y_sel == 2'b10 && !carry_in) begin
      p_xfer_r4: assert (sum_out == opa && !carry_out)
        else $error("R4 transfer mismatch");
    end
    if (known && y_sel == 2'b10 && carry_in) begin
      p_inc_r5: assert (sum_out == opa + 1'b1 && carry_out == (&opa))
        else $error("R5 increment mismatch");
    end
    if (known && y_sel == 2'b11 && !carry_in) begin
      p_dec_r6: assert (sum_out == opa - 1'b1 && carry_out == (|opa))
        else $error("R6 decrement mismatch");
    end
    if (known && y_sel == 2'b11 && carry_in) begin
      p_pass_r7: assert (sum_out == opa && carry_out)
        else $error("R7 pass mismatch");
    end
  end
endmodule

bind mux_adder_arith mxa_checker #(.WIDTH(WIDTH)) u_mxa_chk (
  .opa      (opa),
  .opb      (opb),
  .y_sel    (y_sel),
  .carry_in (carry_in),
  .sum_out  (sum_out),
  .carry_out(carry_out)
);

// File: tb/test_mux_adder_arith.sv
module test_mux_adder_arith;
  localparam int W = 32;
  localparam int NV = 14;
  // vector: {a[32], b[32], sel[2], cin[1], exp_cout[1], exp_sum[32]}
  localparam logic [99:0] VEC [NV] = '{
    {32'h0000_0001, 32'h0000_0002, 2'b00, 1'b0, 1'b0, 32'h0000_0003},
    {32'hFFFF_FFFF, 32'h0000_0001, 2'b00, 1'b0, 1'b1, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, 1'b1, 1'b1, 32'hFFFF_FFFF},
    {32'h8000_0000, 32'h8000_0000, 2'b00, 1'b0, 1'b1, 32'h0000_0000},
    {32'h0000_0010, 32'h0000_0003, 2'b01, 1'b1, 1'b1, 32'h0000_000D},
    {32'h0000_0003, 32'h0000_0010, 2'b01, 1'b1, 1'b0, 32'hFFFF_FFF3},
    {32'h0000_0010, 32'h0000_0003, 2'b01, 1'b0, 1'b1, 32'h0000_000C},
    {32'h0000_0005, 32'h0000_0005, 2'b01, 1'b0, 1'b0, 32'hFFFF_FFFF},
    {32'h0000_1234, 32'hFFFF_FFFF, 2'b10, 1'b0, 1'b0, 32'h0000_1234},
    {32'hFFFF_FFFF, 32'h0000_0000, 2'b10, 1'b1, 1'b1, 32'h0000_0000},
    {32'h0000_0000, 32'h0000_0000, 2'b11, 1'b0, 1'b0, 32'hFFFF_FFFF},
    {32'h8000_0000, 32'h0000_0000, 2'b11, 1'b0, 1'b1, 32'h7FFF_FFFF},
    {32'h8000_0000, 32'h5555_5555, 2'b11, 1'b1, 1'b1, 32'h8000_0000},
    {32'h0000_0FFF, 32'h0000_0001, 2'b10, 1'b1, 1'b0, 32'h0000_1000}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] opa, opb, sum_out;
  logic [1:0]   y_sel;
  logic         carry_in, carry_out;
  int checks = 0;
  int errors = 0;

  mux_adder_arith i_mux_adder_arith (
    .opa(opa), .opb(opb), .y_sel(y_sel), .carry_in(carry_in),
    .sum_out(sum_out), .carry_out(carry_out)
  );

  function automatic string req_of(input logic [1:0] s, input logic c);
    case ({s, c})
      3'b000, 3'b001: return "R1";
      3'b011:         return "R2";
      3'b010:         return "R3";
      3'b100:         return "R4";
      3'b101:         return "R5";
      3'b110:         return "R6";
      default:        return "R7";
    endcase
  endfunction

  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic [1:0] s, input logic c);
    logic [W-1:0] y;
    case (s)
      2'b00:   y = b;
      2'b01:   y = ~b;
      2'b10:   y = '0;
      default: y = '1;
    endcase
    return {1'b0, a} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic check(input string tag, input logic [W:0] exp);
    checks++;
    if ({carry_out, sum_out} !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h sel=%b cin=%b got %h expected %h",
               tag, opa, opb, y_sel, carry_in, {carry_out, sum_out}, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [1:0] s, input logic c);
    @(negedge clk);
    opa = a; opb = b; y_sel = s; carry_in = c;
    #1;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // initial state: all-zero inputs give a zero result (R1)
    apply('0, '0, 2'b00, 1'b0);
    check("R1", 33'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][99:68], VEC[i][67:36], VEC[i][35:34], VEC[i][33]);
      check(req_of(VEC[i][35:34], VEC[i][33]), VEC[i][32:0]);
    end

    // R4/R7: opb is ignored; sweep opb with opa held
    for (int i = 0; i < 4; i++) begin
      apply(32'hA5A5_0F0F, 32'h1 << (i * 9), 2'b10, 1'b0);
      check("R4", {1'b0, 32'hA5A5_0F0F});
      apply(32'hA5A5_0F0F, ~(32'h1 << (i * 9)), 2'b11, 1'b1);
      check("R7", {1'b1, 32'hA5A5_0F0F});
    end

    // R8: same inputs after a different history give the same outputs,
    // within one step and with no clock edge between
    apply(32'hFFFF_FFFF, 32'h0, 2'b10, 1'b1);
    opa = 32'h0000_0007; opb = 32'h0000_0009; y_sel = 2'b01; carry_in = 1'b1;
    #0.5;
    check("R8", {1'b0, 32'hFFFF_FFFE});
    opa = 32'h0; y_sel = 2'b11; carry_in = 1'b0;
    #0.5;
    check("R8", {1'b0, 32'hFFFF_FFFF});

    // random operands, every select and carry
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb;
      logic [1:0]   rs;
      logic         rc;
      ra = $urandom(); rb = $urandom(); rs = 2'($urandom()); rc = 1'($urandom());
      if (i % 8 == 0) ra = 32'h8000_0000;
      if (i % 8 == 1) rb = '1;
      if (i % 8 == 2) ra = '0;
      apply(ra, rb, rs, rc);
      check(req_of(rs, rc), model(ra, rb, rs, rc));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule